// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a level-one data cache placed between a processor load/store port and a slower memory. Every byte address is split into a tag, a line index and an offset within a 32-byte line. Each line has exactly one possible home, so no replacement choice is needed. Each line keeps a valid flag, the stored tag and a 256-bit block. A load that hits returns the addressed 64-bit word. A load that misses stalls the processor, fetches the whole block through a request/acknowledge read port, installs it and then completes as a hit.

Stores are write-through and never allocate. Every accepted store is queued in a small write buffer that drains through its own valid/ready port. A store that hits also merges its enabled bytes into the cached word. While a refill is outstanding, the buffer stops draining so that the load is served first. A load miss whose block matches a store that is still queued waits until that store has drained, so the refill always carries the newest data.

Top module: `wtc_dcache`

## Requirements
- R1: After reset every line is invalid: `reqStall`, `rspValid`, `memRdReq` and `wbValid` are low, and the first load to any address misses and issues a refill.
- R2: The address splits as tag = bits [ADDR_W-1:IDX_W+OFF_W], line index = bits [IDX_W+OFF_W-1:OFF_W] and word select = bits [OFF_W-1:3]. A hit needs the line valid and its stored tag equal to the address tag.
- R3: A load that hits keeps `reqStall` low. `rspValid` rises in the cycle after the accepting edge, and `rspData` then holds the addressed word.
- R4: A load miss raises `reqStall` and `memRdReq`, with `memRdAddr` = address bits [ADDR_W-1:OFF_W]. Both stay high until `memRdAck`. Word k of the block is `memRdData[64k+63:64k]`. After the acknowledge the load completes as a hit with the refilled word.
- R5: A store that hits updates only the addressed word, and within it only the bytes whose `reqBe` bit is set (bit i selects bits [8i+7:8i]). A later load returns the merged value.
- R6: Every accepted store appears exactly once on the write-buffer port, in acceptance order, carrying its address, data and byte enables.
- R7: A store that misses does not fill or change any line. The line keeps its old block, and a later load to the stored address misses and refills.
- R8: While WB_DEPTH stores are queued, a new store is stalled until an entry drains.
- R9: While `memRdReq` is high, `wbValid` is low, and queued stores are held rather than dropped.
- R10: A load miss whose block address matches a queued store issues no refill until that store has drained. The load then returns the stored bytes.
- R11: A refill replaces whatever block the line held, so two blocks with the same index evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present, held while stalled |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | WORD_W | Store data |
| reqBe | input | WORD_W/8 | Store byte enables |
| reqStall | output | 1 | Request not accepted this cycle |
| rspValid | output | 1 | Load data valid |
| rspData | output | WORD_W | Load data |
| memRdReq | output | 1 | Block refill request |
| memRdAddr | output | ADDR_W-OFF_W | Block address of refill |
| memRdAck | input | 1 | Refill data present |
| memRdData | input | 8<<OFF_W | Whole refilled block |
| wbValid | output | 1 | Buffered store offered to memory |
| wbAddr | output | ADDR_W | Address of buffered store |
| wbData | output | WORD_W | Data of buffered store |
| wbBe | output | WORD_W/8 | Byte enables of buffered store |
| wbReady | input | 1 | Memory accepts the buffered store |

## Verification
The hardest case to reach is a load miss whose block is still held in the write buffer. It needs a store that missed to remain queued at the moment the load to that block arrives. The bench sets this up by holding `wbReady` low, storing to a block that is not cached and then issuing the load. For several cycles it observes that no refill request appears. Only then does it release the buffer, and it expects the refilled word to carry the stored bytes. The same drain gating is used to fill the buffer to force store stalls, and to hold queued stores across an unrelated refill so that drain priority can be observed.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  // strobes from the controller to the datapath and write buffer
  typedef struct packed {
    logic fillWrite;   // install refilled block
    logic storeWrite;  // merge store into cached word
    logic wbPush;      // enqueue store
    logic rspLoad;     // capture load data
    logic drainEn;     // buffer may offer its head
  } ctrlStrobes_t;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int ADDR_W = 34,
  parameter int OFF_W  = 5,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    push,
  input  logic [ADDR_W-1:0]       pushAddr,
  input  logic [WORD_W-1:0]       pushData,
  input  logic [WORD_W/8-1:0]     pushBe,
  input  logic                    drainEn,
  input  logic                    outReady,
  output logic                    outValid,
  output logic [ADDR_W-1:0]       outAddr,
  output logic [WORD_W-1:0]       outData,
  output logic [WORD_W/8-1:0]     outBe,
  output logic                    full,
  input  logic [ADDR_W-OFF_W-1:0] queryBlk,
  output logic                    match
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BE_W  = WORD_W / 8;

  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [DEPTH-1:0]  slotValid, slotHit;
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [WORD_W-1:0] entData [DEPTH];
  logic [BE_W-1:0]   entBe   [DEPTH];
  logic              popFire;

  assign full     = slotValid[tailPtr];
  assign outValid = drainEn && slotValid[headPtr];
  assign outAddr  = entAddr[headPtr];
  assign outData  = entData[headPtr];
  assign outBe    = entBe[headPtr];
  assign popFire  = outValid && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      headPtr   <= '0;
      tailPtr   <= '0;
    end else begin
      if (push) begin
        slotValid[tailPtr] <= 1'b1;
        tailPtr            <= tailPtr + PTR_W'(1);
      end
      if (popFire) begin
        slotValid[headPtr] <= 1'b0;
        headPtr            <= headPtr + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      entAddr[tailPtr] <= pushAddr;
      entData[tailPtr] <= pushData;
      entBe[tailPtr]   <= pushBe;
    end
  end

  // block-address compare against every occupied slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slotCmp
    assign slotHit[g] = slotValid[g] && (entAddr[g][ADDR_W-1:OFF_W] == queryBlk);
  end
  assign match = |slotHit;
endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 5,
  parameter int WORD_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [WORD_W-1:0]   reqWdata,
  input  logic [WORD_W/8-1:0] reqBe,
  input  logic [(8<<OFF_W)-1:0] memRdData,
  output logic                hit,
  output logic [WORD_W-1:0]   rspData
);
  localparam int LINES  = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 << OFF_W;
  localparam int BE_W   = WORD_W / 8;
  localparam int BYTE_W = $clog2(BE_W);
  localparam int SEL_W  = OFF_W - BYTE_W;

  logic [LINES-1:0]  validBits;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINE_W-1:0] dataMem [LINES];

  logic [IDX_W-1:0]  lineIdx;
  logic [TAG_W-1:0]  addrTag;
  logic [SEL_W-1:0]  wordSel;
  logic [WORD_W-1:0] lineWord;

  assign lineIdx  = reqAddr[OFF_W +: IDX_W];
  assign addrTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign wordSel  = reqAddr[BYTE_W +: SEL_W];
  assign hit      = validBits[lineIdx] && (tagMem[lineIdx] == addrTag);
  assign lineWord = dataMem[lineIdx][int'(wordSel)*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rstN) validBits <= '0;
    else if (strobes.fillWrite) validBits[lineIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.fillWrite) begin
      tagMem[lineIdx]  <= addrTag;
      dataMem[lineIdx] <= memRdData;
    end else if (strobes.storeWrite) begin
      for (int b = 0; b < BE_W; b++) begin
        if (reqBe[b]) dataMem[lineIdx][int'(wordSel)*WORD_W + b*8 +: 8] <= reqWdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else if (strobes.rspLoad) rspData <= lineWord;
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         hit,
  input  logic         wbFull,
  input  logic         wbMatch,
  input  logic         memRdAck,
  output ctrlStrobes_t strobes,
  output logic         reqStall,
  output logic         memRdReq,
  output logic         rspValid
);
  typedef enum logic {ST_IDLE, ST_FILL} ctrlState_t;
  ctrlState_t state, stateNext;

  logic isLoad, isStore;
  assign isLoad  = reqValid && !reqWrite;
  assign isStore = reqValid && reqWrite;

  always_comb begin
    strobes   = '0;
    reqStall  = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        strobes.drainEn = 1'b1;
        if (isLoad) begin
          if (hit) begin
            strobes.rspLoad = 1'b1;
          end else begin
            reqStall = 1'b1;
            // aliasing store still queued: let it drain first
            if (!wbMatch) stateNext = ST_FILL;
          end
        end
        if (isStore) begin
          if (wbFull) begin
            reqStall = 1'b1;
          end else begin
            strobes.wbPush     = 1'b1;
            strobes.storeWrite = hit;
          end
        end
      end
      ST_FILL: begin
        reqStall = 1'b1;
        if (memRdAck) begin
          strobes.fillWrite = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memRdReq = (state == ST_FILL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= strobes.rspLoad;
    end
  end
endmodule

// File: rtl/wtc_dcache.sv
module wtc_dcache
  import wtc_pkg::*;
#(
  parameter int ADDR_W   = 34,
  parameter int IDX_W    = 8,
  parameter int OFF_W    = 5,
  parameter int WORD_W   = 64,
  parameter int WB_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [WORD_W-1:0]       reqWdata,
  input  logic [WORD_W/8-1:0]     reqBe,
  output logic                    reqStall,
  output logic                    rspValid,
  output logic [WORD_W-1:0]       rspData,
  output logic                    memRdReq,
  output logic [ADDR_W-OFF_W-1:0] memRdAddr,
  input  logic                    memRdAck,
  input  logic [(8<<OFF_W)-1:0]   memRdData,
  output logic                    wbValid,
  output logic [ADDR_W-1:0]       wbAddr,
  output logic [WORD_W-1:0]       wbData,
  output logic [WORD_W/8-1:0]     wbBe,
  input  logic                    wbReady
);
  ctrlStrobes_t strobes;
  logic hit, wbFull, wbMatch;

  assign memRdAddr = reqAddr[ADDR_W-1:OFF_W];

  wtc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(hit), .wbFull(wbFull), .wbMatch(wbMatch), .memRdAck(memRdAck),
    .strobes(strobes), .reqStall(reqStall), .memRdReq(memRdReq), .rspValid(rspValid)
  );

  wtc_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .memRdData(memRdData), .hit(hit), .rspData(rspData)
  );

  wtc_wbuf #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_W(WORD_W), .DEPTH(WB_DEPTH)) i_wbuf (
    .clk(clk), .rstN(rstN), .push(strobes.wbPush), .pushAddr(reqAddr), .pushData(reqWdata),
    .pushBe(reqBe), .drainEn(strobes.drainEn), .outReady(wbReady), .outValid(wbValid),
    .outAddr(wbAddr), .outData(wbData), .outBe(wbBe), .full(wbFull),
    .queryBlk(reqAddr[ADDR_W-1:OFF_W]), .match(wbMatch)
  );
endmodule

// File: rtl/wtc_dcache_chk.sv
module wtc_dcache_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic reqStall,
  input logic rspValid,
  input logic memRdReq,
  input logic memRdAck,
  input logic wbValid,
  input logic wbFull,
  input logic wbMatch
);
  // R8: store with a full buffer is never accepted
  a_r8_full_stalls_store: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && wbFull |-> reqStall);

  // R9: buffer is not offered while a refill is outstanding
  a_r9_read_priority: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !wbValid);

  // R10: no refill while an aliasing store is queued
  a_r10_no_stale_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !wbMatch);

  // R4: refill request held until acknowledged, processor stalled meanwhile
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdAck |=> memRdReq);
  a_r4_miss_stalls: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> reqStall);

  // R3: a response only follows an accepted load
  a_r3_rsp_after_load: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite && !reqStall));

  // R6: an accepted store is offered on the buffer port next cycle
  a_r6_store_queued: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && !reqStall |=> wbValid);
endmodule

bind wtc_dcache wtc_dcache_chk i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqStall(reqStall), .rspValid(rspValid), .memRdReq(memRdReq), .memRdAck(memRdAck),
  .wbValid(wbValid), .wbFull(wbFull), .wbMatch(wbMatch)
);

// File: tb/test_wtc_dcache.sv
module test_wtc_dcache;
  localparam int ADDR_W = 16, IDX_W = 4, OFF_W = 5, WORD_W = 64, WB_DEPTH = 4;
  localparam int LINE_W = 8 << OFF_W;
  localparam int LAT    = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic [7:0]  reqBe = '0;
  logic reqStall, rspValid, memRdReq, memRdAck = 1'b0, wbValid, wbReady = 1'b1;
  logic [63:0] rspData, wbData;
  logic [ADDR_W-OFF_W-1:0] memRdAddr;
  logic [LINE_W-1:0] memRdData = '0;
  logic [ADDR_W-1:0] wbAddr;
  logic [7:0] wbBe;

  always #5 clk = ~clk;

  wtc_dcache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W),
               .WB_DEPTH(WB_DEPTH)) i_wtc_dcache (.*);

  int checks = 0, fails = 0, fills = 0, prioViol = 0, latCnt = 0;
  logic [63:0] refMem [int];
  logic [63:0] memMem [int];
  typedef struct { logic [ADDR_W-1:0] a; logic [63:0] d; logic [7:0] be; } st_t;
  st_t expQ [$];

  function automatic logic [63:0] pat(int w);
    return 64'h0123_4567_89AB_CDEF ^ ({48'd0, w[15:0]} * 64'h0001_0003_0007_000B);
  endfunction
  function automatic logic [63:0] refRd(int w);
    return refMem.exists(w) ? refMem[w] : pat(w);
  endfunction
  function automatic logic [63:0] memRd(int w);
    return memMem.exists(w) ? memMem[w] : pat(w);
  endfunction
  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] d, logic [7:0] be);
    logic [63:0] r = old;
    for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction
  function automatic logic [ADDR_W-1:0] mkAddr(int tag, int idx, int word);
    return {tag[6:0], idx[3:0], word[1:0], 3'b000};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // refill responder: acknowledge LAT cycles after the request
  always @(negedge clk) begin
    if (memRdReq && !memRdAck) begin
      if (latCnt == LAT) begin
        for (int k = 0; k < 4; k++) memRdData[k*64 +: 64] <= memRd(int'({memRdAddr, k[1:0]}));
        memRdAck <= 1'b1;
        latCnt   <= 0;
      end else latCnt <= latCnt + 1;
    end else memRdAck <= 1'b0;
  end

  // write-buffer sink and port monitors
  always @(posedge clk) begin
    if (rstN) begin
      if (memRdReq && memRdAck) fills++;
      if (memRdReq && wbValid) prioViol++;
      if (wbValid && wbReady) begin
        if (expQ.size() == 0) check("R6 unexpected buffered store", 64'(wbAddr), 64'hX);
        else begin
          check("R6 buffered address", 64'(wbAddr), 64'(expQ[0].a));
          check("R6 buffered data", wbData, expQ[0].d);
          check("R6 buffered enables", 64'(wbBe), 64'(expQ[0].be));
          void'(expQ.pop_front());
        end
        memMem[int'(wbAddr >> 3)] = merge(memRd(int'(wbAddr >> 3)), wbData, wbBe);
      end
    end
  end

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [63:0] d,
                        input logic [7:0] be, output logic [63:0] rd, output int stallCyc);
    bit st;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    stallCyc = 0;
    while (1) begin
      #4; st = reqStall;
      @(posedge clk);
      if (!st) break;
      stallCyc++;
      @(negedge clk);
    end
    if (wr) begin
      refMem[int'(a >> 3)] = merge(refRd(int'(a >> 3)), d, be);
      expQ.push_back('{a: a, d: d, be: be});
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    rd = rspData;
    if (!wr) check("R3 rspValid after load", 64'(rspValid), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] rd;
    logic [ADDR_W-1:0] a;
    int sc, f0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    check("R1 reset reqStall", 64'(reqStall), 0);
    check("R1 reset rspValid", 64'(rspValid), 0);
    check("R1 reset memRdReq", 64'(memRdReq), 0);
    check("R1 reset wbValid", 64'(wbValid), 0);

    // R1 R2 R4: cold sweep, one refill per line
    for (int i = 0; i < 16; i++) for (int w = 0; w < 4; w++) begin
      a = mkAddr(i + 1, i, w); f0 = fills;
      access(0, a, '0, '0, rd, sc);
      check("R4 refilled word", rd, refRd(int'(a >> 3)));
      check("R2 R4 refill count", 64'(fills - f0), (w == 0) ? 64'd1 : 64'd0);
      if (w == 0) check("R4 miss stalls", 64'(sc > LAT), 64'd1);
    end
    // R3: warm sweep, every access hits without stall
    for (int i = 0; i < 16; i++) for (int w = 0; w < 4; w++) begin
      a = mkAddr(i + 1, i, w); f0 = fills;
      access(0, a, '0, '0, rd, sc);
      check("R3 hit data", rd, refRd(int'(a >> 3)));
      check("R3 hit no stall", 64'(sc), 0);
      check("R3 hit no refill", 64'(fills - f0), 0);
    end
    // R5: byte-enable sweep on line 3
    for (int be = 0; be < 256; be++) begin
      a = mkAddr(4, 3, be % 4); f0 = fills;
      access(1, a, pat(be) ^ 64'hFFFF_0000_FFFF_0000, 8'(be), rd, sc);
      access(0, a, '0, '0, rd, sc);
      check("R5 merged store hit", rd, refRd(int'(a >> 3)));
      check("R5 store hit no refill", 64'(fills - f0), 0);
    end
    repeat (10) @(negedge clk);
    // R7: store miss leaves line 5 intact and does not allocate
    a = mkAddr(7'h50, 5, 1);
    access(1, a, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, rd, sc);
    repeat (6) @(negedge clk);
    f0 = fills;
    access(0, mkAddr(6, 5, 1), '0, '0, rd, sc);
    check("R7 old line kept", rd, refRd(int'(mkAddr(6, 5, 1) >> 3)));
    check("R7 old line still hits", 64'(fills - f0), 0);
    access(0, a, '0, '0, rd, sc);
    check("R7 no allocate, refill needed", 64'(fills - f0), 1);
    check("R7 stored value after refill", rd, refRd(int'(a >> 3)));
    // R8: full buffer stalls the next store
    wbReady = 1'b0;
    for (int k = 0; k < WB_DEPTH; k++) begin
      access(1, mkAddr(7'h20, k, 0), pat(k + 900), 8'h0F, rd, sc);
      check("R8 store accepted below full", 64'(sc), 0);
    end
    fork
      access(1, mkAddr(7'h20, 4, 0), pat(950), 8'hF0, rd, sc);
      begin
        repeat (4) @(negedge clk); #4;
        check("R8 store stalled while full", 64'(reqStall), 1);
        @(negedge clk); wbReady = 1'b1;
      end
    join
    check("R8 stall duration", 64'(sc >= 3), 1);
    repeat (10) @(negedge clk);
    // R10: load miss aliasing a queued store waits for the drain
    wbReady = 1'b0;
    a = mkAddr(7'h60, 7, 2);
    access(1, a, 64'h1122_3344_5566_7788, 8'hF0, rd, sc);
    f0 = fills;
    fork
      access(0, a, '0, '0, rd, sc);
      begin
        repeat (8) @(negedge clk); #4;
        check("R10 no refill while alias queued", 64'(memRdReq), 0);
        check("R10 load stalled", 64'(reqStall), 1);
        @(negedge clk); wbReady = 1'b1;
      end
    join
    check("R10 load sees stored bytes", rd, refRd(int'(a >> 3)));
    check("R10 single refill", 64'(fills - f0), 1);
    repeat (10) @(negedge clk);
    // R9: refill proceeds while stores stay queued and unoffered
    wbReady = 1'b0;
    access(1, mkAddr(10, 9, 0), 64'hA5A5, 8'h03, rd, sc);
    access(1, mkAddr(11, 10, 1), 64'h5A5A, 8'h0C, rd, sc);
    f0 = fills;
    access(0, mkAddr(7'h70, 11, 3), '0, '0, rd, sc);
    check("R9 refill done with queue held", 64'(fills - f0), 1);
    check("R9 refill data", rd, refRd(int'(mkAddr(7'h70, 11, 3) >> 3)));
    check("R9 no store offered during refill", 64'(prioViol), 0);
    check("R9 stores still queued", 64'(wbValid), 1);
    wbReady = 1'b1;
    repeat (10) @(negedge clk);
    // R11 R2: same index, different tag evicts
    f0 = fills;
    access(0, mkAddr(3, 2, 0), '0, '0, rd, sc);
    check("R11 resident line hits", 64'(fills - f0), 0);
    access(0, mkAddr(7'h41, 2, 0), '0, '0, rd, sc);
    check("R11 conflicting tag refills", 64'(fills - f0), 1);
    check("R2 conflicting block data", rd, refRd(int'(mkAddr(7'h41, 2, 0) >> 3)));
    access(0, mkAddr(3, 2, 0), '0, '0, rd, sc);
    check("R11 evicted line refills", 64'(fills - f0), 2);
    check("R11 evicted line data", rd, refRd(int'(mkAddr(3, 2, 0) >> 3)));
    repeat (10) @(negedge clk);
    check("R6 every store drained", 64'(expQ.size()), 0);
    summary();
  end
endmodule